// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm Registers

This block is a memory-mapped real-time clock. A 32.768 kHz tick, arriving as a one-cycle enable in the bus clock domain, drives a millisecond counter through a fractional accumulator. Each millisecond wrap advances a 32-bit seconds count. The counting side is not read directly by the bus. After every eight ticks a short copy window opens. A busy flag reads 1 during that window, and at its end the seconds and milliseconds values move into the bus-visible registers.

The host reaches the block through a 32-bit read/write port with one cycle of read latency. Reading the milliseconds register also latches the bus-side seconds into a shadow register, so a later read of the shadow returns seconds that match the milliseconds just read. Three alarm comparators are provided: two on seconds and one on milliseconds. Each alarm treats a stored zero as disabled. An alarm hit sets a write-one-to-clear status bit, and the level interrupt output is high while any status bit is set and its mask bit is set.

Top module: `rtc_sec_top`

## Requirements
- R1: Each tick adds MS_PER_S to an accumulator modulo TICK_HZ, and a carry advances milliseconds. Milliseconds run 0 to MS_PER_S-1. When milliseconds wrap from MS_PER_S-1 to 0, seconds increment modulo 2^32.
- R2: After every TICKS_PER_COPY ticks, the busy flag (offset 0x04, bit 0) is 1 for exactly COPY_CYCLES cycles. Consecutive windows start TICKS_PER_COPY ticks apart. The seconds and milliseconds registers take the counting-side values when the window closes.
- R3: A write presented while busy is 1 has no effect. Reads are served at all times.
- R4: A write to seconds (offset 0x08) reloads the seconds count and zeroes the milliseconds and the accumulator. A read of 0x08 returns the bus-side copy, so the new value appears there only after the next copy window.
- R5: A read of milliseconds (offset 0x10) stores the bus-side seconds in the shadow register (offset 0x0C) in the same cycle. A later read of 0x0C returns that value.
- R6: Seconds alarms at 0x14 and 0x18 set status bit 0 and bit 1 on the tick where the seconds count steps to a value equal to theirs. A status bit sets whether or not its mask bit is set.
- R7: A seconds alarm that holds zero never sets its status bit, including when the count wraps to zero.
- R8: The millisecond alarm at 0x1C sets status bit 2 when milliseconds step to its nonzero value. A value of zero disables it.
- R9: Status (offset 0x2C) is write-one-to-clear: a written 1 clears that bit and a written 0 leaves it unchanged. Bits 3 and 4 have no source in this block, and bits 31 to 5 read 0. An event and a clear that arrive in the same cycle leave the bit set.
- R10: Mask (offset 0x28) keeps bits 4 to 0. Higher written bits are dropped and read as 0.
- R11: irq_o is high exactly while some status bit and the mask bit in the same position are both 1.
- R12: Read data appears one cycle after the request. After reset every register reads 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz period |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the request |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench finds the copy window by polling busy. It then checks that the window lasts exactly COPY_CYCLES cycles and repeats every eight ticks. A design with a wrong divider or an off-by-one window length would shift the edges that the bench samples. One write is placed inside the busy window, and the bench reads the register back afterwards. A design that accepted that write would return the new value.

A seconds read taken right after a load must still return the old value. This catches a design that exposes the counting side directly. The zero-alarm case loads 0xFFFFFFFF and lets the count wrap to zero. A design that compares without the nonzero guard would raise a false alarm at that point. The bench also checks that a masked-off event still sets its status bit, and that a write of zero to status clears nothing.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

  localparam int DATA_W = 32;
  localparam int EVT_W  = 5;
  localparam int ADDR_W = 8;

  // register offsets (decoded by the bus port)
  localparam logic [ADDR_W-1:0] OFS_BUSY   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MS     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SALM0  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SALM1  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_MSALM  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h2C;

  // event bit positions, shared by mask and status
  localparam int EV_SALM0 = 0;
  localparam int EV_SALM1 = 1;
  localparam int EV_MSALM = 2;
  localparam int EV_SCDN  = 3;
  localparam int EV_MSCDN = 4;

  typedef struct packed {
    logic              carry;
    logic [DATA_W-1:0] acc;
  } frac_t;

  // one accumulator step: add inc, wrap at modulus, report the carry
  function automatic frac_t frac_step(input logic [DATA_W-1:0] acc,
                                     input logic [DATA_W-1:0] inc,
                                     input logic [DATA_W-1:0] modulus);
    frac_t r;
    logic [DATA_W-1:0] sum;
    sum     = acc + inc;
    r.carry = (sum >= modulus);
    r.acc   = r.carry ? (sum - modulus) : sum;
    return r;
  endfunction

  // a stored zero disables the comparator
  function automatic logic alarm_hit(input logic [DATA_W-1:0] target,
                                     input logic [DATA_W-1:0] value);
    return (target != '0) && (target == value);
  endfunction

endpackage

// File: rtl/rtc_sec_timebase.sv
module rtc_sec_timebase
  import rtc_sec_pkg::*;
#(
  parameter int TICK_HZ  = 32768,
  parameter int MS_PER_S = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] ms_o,
  output logic              ms_evt_o,
  output logic              sec_evt_o,
  output logic [DATA_W-1:0] ms_next_o,
  output logic [DATA_W-1:0] sec_next_o
);

  localparam int MS_W = $clog2(MS_PER_S);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_S - 1);

  logic [DATA_W-1:0] acc_q;
  logic [MS_W-1:0]   ms_q;
  logic [DATA_W-1:0] sec_q;
  frac_t             step;
  logic              ms_wrap;
  logic [MS_W-1:0]   ms_inc;

  always_comb begin
    step       = frac_step(acc_q, DATA_W'(MS_PER_S), DATA_W'(TICK_HZ));
    ms_wrap    = (ms_q == MS_LAST);
    ms_inc     = ms_wrap ? '0 : ms_q + 1'b1;
    ms_evt_o   = tick_i && !load_i && step.carry;
    sec_evt_o  = ms_evt_o && ms_wrap;
    ms_next_o  = {{(DATA_W-MS_W){1'b0}}, ms_inc};
    sec_next_o = sec_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ms_q  <= '0;
      sec_q <= '0;
    end else if (load_i) begin
      acc_q <= '0;
      ms_q  <= '0;
      sec_q <= load_val_i;
    end else if (tick_i) begin
      acc_q <= step.acc;
      if (step.carry) begin
        ms_q <= ms_inc;
        if (ms_wrap) sec_q <= sec_next_o;
      end
    end
  end

  assign sec_o = sec_q;
  assign ms_o  = {{(DATA_W-MS_W){1'b0}}, ms_q};

endmodule

// File: rtl/rtc_sec_mirror.sv
module rtc_sec_mirror
  import rtc_sec_pkg::*;
#(
  parameter int TICKS_PER_COPY = 8,
  parameter int COPY_CYCLES    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] sec_i,
  input  logic [DATA_W-1:0] ms_i,
  output logic              busy_o,
  output logic              copy_o,
  output logic [DATA_W-1:0] bus_sec_o,
  output logic [DATA_W-1:0] bus_ms_o
);

  localparam int DIV_W = (TICKS_PER_COPY > 1) ? $clog2(TICKS_PER_COPY) : 1;
  localparam int CYC_W = $clog2(COPY_CYCLES) + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_COPY - 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(COPY_CYCLES - 1);

  logic [DIV_W-1:0] div_q;
  logic [CYC_W-1:0] cyc_q;
  logic             busy_q;
  logic             start;

  assign start  = tick_i && (div_q == DIV_LAST) && !busy_q;
  assign copy_o = busy_q && (cyc_q == CYC_LAST);
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      cyc_q     <= '0;
      busy_q    <= 1'b0;
      bus_sec_o <= '0;
      bus_ms_o  <= '0;
    end else begin
      if (tick_i) div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      if (start) begin
        busy_q <= 1'b1;
        cyc_q  <= '0;
      end else if (copy_o) begin
        busy_q    <= 1'b0;
        bus_sec_o <= sec_i;
        bus_ms_o  <= ms_i;
      end else if (busy_q) begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_sec_events.sv
module rtc_sec_events
  import rtc_sec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_evt_i,
  input  logic [DATA_W-1:0] sec_next_i,
  input  logic              ms_evt_i,
  input  logic [DATA_W-1:0] ms_next_i,
  input  logic [DATA_W-1:0] salm0_i,
  input  logic [DATA_W-1:0] salm1_i,
  input  logic [DATA_W-1:0] msalm_i,
  input  logic              stat_we_i,
  input  logic              mask_we_i,
  input  logic [EVT_W-1:0]  wbits_i,
  output logic [EVT_W-1:0]  status_o,
  output logic [EVT_W-1:0]  mask_o,
  output logic              irq_o
);

  logic [EVT_W-1:0] hit;
  logic [EVT_W-1:0] clr;

  always_comb begin
    hit           = '0;
    hit[EV_SALM0] = sec_evt_i && alarm_hit(salm0_i, sec_next_i);
    hit[EV_SALM1] = sec_evt_i && alarm_hit(salm1_i, sec_next_i);
    hit[EV_MSALM] = ms_evt_i  && alarm_hit(msalm_i, ms_next_i);
    hit[EV_SCDN]  = 1'b0;
    hit[EV_MSCDN] = 1'b0;
    clr           = stat_we_i ? wbits_i : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      mask_o   <= '0;
    end else begin
      status_o <= (status_o & ~clr) | hit;
      if (mask_we_i) mask_o <= wbits_i;
    end
  end

  assign irq_o = |(status_o & mask_o);

endmodule

// File: rtl/rtc_sec_top.sv
module rtc_sec_top
  import rtc_sec_pkg::*;
#(
  parameter int TICK_HZ        = 32768,
  parameter int MS_PER_S       = 1000,
  parameter int TICKS_PER_COPY = 8,
  parameter int COPY_CYCLES    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic              busy, copy;
  logic              wr_ok, rd_ms;
  logic [DATA_W-1:0] sec_q, ms_core;
  logic              ms_evt, sec_evt;
  logic [DATA_W-1:0] ms_next, sec_next;
  logic [DATA_W-1:0] bus_sec, bus_ms;
  logic [DATA_W-1:0] shadow_q, alm0_q, alm1_q, msalm_q;
  logic [EVT_W-1:0]  status_q, mask_q;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ok = req_i && we_i && !busy;
  assign rd_ms = req_i && !we_i && (addr_i == OFS_MS);

  rtc_sec_timebase #(.TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S)) u_time (
    .clk, .rst_n, .tick_i,
    .load_i     (wr_ok && (addr_i == OFS_SEC)),
    .load_val_i (wdata_i),
    .sec_o      (sec_q),
    .ms_o       (ms_core),
    .ms_evt_o   (ms_evt),
    .sec_evt_o  (sec_evt),
    .ms_next_o  (ms_next),
    .sec_next_o (sec_next)
  );

  rtc_sec_mirror #(.TICKS_PER_COPY(TICKS_PER_COPY), .COPY_CYCLES(COPY_CYCLES)) u_mirror (
    .clk, .rst_n, .tick_i,
    .sec_i     (sec_q),
    .ms_i      (ms_core),
    .busy_o    (busy),
    .copy_o    (copy),
    .bus_sec_o (bus_sec),
    .bus_ms_o  (bus_ms)
  );

  rtc_sec_events u_events (
    .clk, .rst_n,
    .sec_evt_i  (sec_evt),
    .sec_next_i (sec_next),
    .ms_evt_i   (ms_evt),
    .ms_next_i  (ms_next),
    .salm0_i    (alm0_q),
    .salm1_i    (alm1_q),
    .msalm_i    (msalm_q),
    .stat_we_i  (wr_ok && (addr_i == OFS_STAT)),
    .mask_we_i  (wr_ok && (addr_i == OFS_MASK)),
    .wbits_i    (wdata_i[EVT_W-1:0]),
    .status_o   (status_q),
    .mask_o     (mask_q),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      OFS_BUSY:   rd_mux = {{(DATA_W-1){1'b0}}, busy};
      OFS_SEC:    rd_mux = bus_sec;
      OFS_SHADOW: rd_mux = shadow_q;
      OFS_MS:     rd_mux = bus_ms;
      OFS_SALM0:  rd_mux = alm0_q;
      OFS_SALM1:  rd_mux = alm1_q;
      OFS_MSALM:  rd_mux = msalm_q;
      OFS_MASK:   rd_mux = {{(DATA_W-EVT_W){1'b0}}, mask_q};
      OFS_STAT:   rd_mux = {{(DATA_W-EVT_W){1'b0}}, status_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      shadow_q <= '0;
      alm0_q   <= '0;
      alm1_q   <= '0;
      msalm_q  <= '0;
    end else begin
      if (req_i && !we_i) rdata_o <= rd_mux;
      if (rd_ms) shadow_q <= bus_sec;
      if (wr_ok && (addr_i == OFS_SALM0)) alm0_q  <= wdata_i;
      if (wr_ok && (addr_i == OFS_SALM1)) alm1_q  <= wdata_i;
      if (wr_ok && (addr_i == OFS_MSALM)) msalm_q <= wdata_i;
    end
  end

endmodule

// File: rtl/rtc_sec_chk.sv
module rtc_sec_chk
  import rtc_sec_pkg::*;
#(
  parameter int MS_PER_S    = 1000,
  parameter int COPY_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              busy,
  input logic              copy,
  input logic [DATA_W-1:0] sec_q,
  input logic [DATA_W-1:0] ms_core,
  input logic              sec_evt,
  input logic [DATA_W-1:0] bus_sec,
  input logic [DATA_W-1:0] shadow_q,
  input logic [DATA_W-1:0] alm0_q,
  input logic [DATA_W-1:0] alm1_q,
  input logic [EVT_W-1:0]  status_q
);

  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= 0;
    else        busy_run <= busy ? busy_run + 1 : 0;
  end

  // R1: milliseconds stay in range
  assert_ms_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ms_core < DATA_W'(MS_PER_S));

  // R1: a seconds event advances the count by one
  assert_sec_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> sec_q == $past(sec_q) + 1);

  // R2: the busy window never runs longer than its length
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= COPY_CYCLES);

  // R2: closing the window publishes the counting-side seconds
  assert_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    copy |=> (bus_sec == $past(sec_q)) && !busy);

  // R3: a write during busy leaves the alarm register as it was
  assert_blocked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_i && we_i && addr_i == OFS_SALM1) |=> $stable(alm1_q));

  // R5: a milliseconds read latches the bus-side seconds
  assert_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && addr_i == OFS_MS) |=> shadow_q == $past(bus_sec));

  // R7: the alarm 0 status only rises while its value is nonzero
  assert_zero_alarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[EV_SALM0]) |-> $past(alm0_q) != '0);

  // R9: unused status bits read zero
  assert_stat_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && addr_i == OFS_STAT) |=> rdata_o[DATA_W-1:EVT_W] == '0);

endmodule

bind rtc_sec_top rtc_sec_chk #(.MS_PER_S(MS_PER_S), .COPY_CYCLES(COPY_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .busy     (busy),
  .copy     (copy),
  .sec_q    (sec_q),
  .ms_core  (ms_core),
  .sec_evt  (sec_evt),
  .bus_sec  (bus_sec),
  .shadow_q (shadow_q),
  .alm0_q   (alm0_q),
  .alm1_q   (alm1_q),
  .status_q (status_q)
);

// File: tb/rtc_sec_top_test.sv
module rtc_sec_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_HZ    = 4096;
  localparam int MS_PER_S   = 1000;
  localparam int TPC        = 8;
  localparam int COPY_LEN   = 4;
  localparam int TICK_DIV   = 2;
  localparam int SEC_CYC    = TICK_HZ * TICK_DIV;

  localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0C, A_MS = 8'h10;
  localparam logic [7:0] A_AL0 = 8'h14, A_AL1 = 8'h18, A_MAL = 8'h1C;
  localparam logic [7:0] A_MSK = 8'h28, A_STA = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  rtc_sec_top #(.TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S),
                .TICKS_PER_COPY(TPC), .COPY_CYCLES(COPY_LEN)) uut (
    .clk, .rst_n, .tick_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      tick_i = ~tick_i;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // returns just after busy has fallen: a long free stretch follows
  task automatic wait_free();
    logic [31:0] v;
    logic prev = 1'b0;
    for (int i = 0; i < 200; i++) begin
      bus_rd(A_BUSY, v);
      if (prev && !v[0]) return;
      prev = v[0];
    end
    check(1'b0, "R2 busy never fell", 32'd0, 32'd1);
  endtask

  task automatic wait_busy();
    logic [31:0] v;
    logic prev = 1'b1;
    for (int i = 0; i < 200; i++) begin
      bus_rd(A_BUSY, v);
      if (!prev && v[0]) return;
      prev = v[0];
    end
    check(1'b0, "R2 busy never rose", 32'd0, 32'd1);
  endtask

  task automatic safe_wr(input logic [7:0] a, input logic [31:0] d);
    wait_free();
    bus_wr(a, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [7:0] regs [8] = '{A_SEC, A_SHD, A_MS, A_AL0, A_AL1, A_MAL, A_MSK, A_STA};
    foreach (regs[i]) begin
      bus_rd(regs[i], v);
      check(v == 0, "R12 reset value", v, 32'd0);
    end
    check(irq_o == 1'b0, "R12 irq after reset", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    int run = 0;
    int gap = 0;
    wait_busy();
    run = 1;
    forever begin
      bus_rd(A_BUSY, v);
      if (!v[0]) break;
      run++;
    end
    check(run == COPY_LEN, "R2 busy length", run, COPY_LEN);
    gap = run + 1;
    forever begin
      bus_rd(A_BUSY, v);
      if (v[0]) break;
      gap++;
    end
    check(gap == TPC * TICK_DIV, "R2 copy period", gap, TPC * TICK_DIV);
  endtask

  task automatic t_blocked();
    logic [31:0] v;
    safe_wr(A_AL1, 32'd7);
    wait_busy();
    bus_wr(A_AL1, 32'h55);
    bus_rd(A_AL1, v);
    check(v == 32'd7, "R3 write during busy ignored", v, 32'd7);
    safe_wr(A_AL1, 32'd0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    safe_wr(A_SEC, 32'd100);
    bus_rd(A_SEC, v);
    check(v == 32'd0, "R4 old value before copy", v, 32'd0);
    wait_free();
    bus_rd(A_SEC, v);
    check(v == 32'd100, "R4 loaded seconds after copy", v, 32'd100);
    bus_rd(A_MS, v);
    check(v <= 32'd5, "R4 milliseconds zeroed on load", v, 32'd0);
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    safe_wr(A_SEC, 32'h1234);
    wait_free();
    bus_rd(A_MS, v);
    bus_rd(A_SHD, v);
    check(v == 32'h1234, "R5 shadow after ms read", v, 32'h1234);
  endtask

  task automatic t_count();
    logic [31:0] v;
    safe_wr(A_STA, 32'hFFFF_FFFF);
    safe_wr(A_MSK, 32'h1);
    safe_wr(A_AL0, 32'd201);
    safe_wr(A_AL1, 32'd201);
    safe_wr(A_MAL, 32'd500);
    safe_wr(A_SEC, 32'd200);
    repeat (3000) @(negedge clk);
    bus_rd(A_STA, v);
    check(v == 0, "R8 no ms alarm before 500", v, 32'd0);
    repeat (2000) @(negedge clk);
    bus_rd(A_STA, v);
    check(v == 32'h4, "R8 ms alarm hit", v, 32'h4);
    check(irq_o == 1'b0, "R11 masked event keeps irq low", {31'd0, irq_o}, 32'd0);
    repeat (SEC_CYC - 5000 + 300) @(negedge clk);
    bus_rd(A_SEC, v);
    check(v == 32'd201, "R1 seconds advanced after one second", v, 32'd201);
    bus_rd(A_MS, v);
    check(v < 32'd200, "R1 milliseconds restarted", v, 32'd0);
    bus_rd(A_STA, v);
    check(v == 32'h7, "R6 both seconds alarms hit regardless of mask", v, 32'h7);
    check(irq_o == 1'b1, "R11 enabled event raises irq", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    safe_wr(A_STA, 32'h2);
    bus_rd(A_STA, v);
    check(v == 32'h5, "R9 one bit cleared", v, 32'h5);
    safe_wr(A_STA, 32'h0);
    bus_rd(A_STA, v);
    check(v == 32'h5, "R9 zero write clears nothing", v, 32'h5);
    safe_wr(A_STA, 32'h1);
    check(irq_o == 1'b0, "R11 irq drops with status", {31'd0, irq_o}, 32'd0);
    safe_wr(A_MSK, 32'hFFFF_FFFF);
    bus_rd(A_MSK, v);
    check(v == 32'h1F, "R10 mask upper bits dropped", v, 32'h1F);
    check(irq_o == 1'b1, "R11 unmasking pending bit raises irq", {31'd0, irq_o}, 32'd1);
    safe_wr(A_STA, 32'hFFFF_FFFF);
    bus_rd(A_STA, v);
    check(v == 32'h0, "R9 all ones clears all", v, 32'h0);
    check(irq_o == 1'b0, "R11 irq low after clear", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_wrap_zero();
    logic [31:0] v;
    safe_wr(A_MAL, 32'd0);
    safe_wr(A_AL1, 32'd0);
    safe_wr(A_AL0, 32'd0);
    safe_wr(A_MSK, 32'h1);
    safe_wr(A_STA, 32'hFFFF_FFFF);
    safe_wr(A_SEC, 32'hFFFF_FFFF);
    repeat (SEC_CYC + 300) @(negedge clk);
    bus_rd(A_SEC, v);
    check(v == 32'd0, "R1 seconds wrap modulo 2^32", v, 32'd0);
    bus_rd(A_STA, v);
    check(v == 32'd0, "R7 zero alarm stays silent at wrap", v, 32'd0);
    check(irq_o == 1'b0, "R7 no irq from zero alarm", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy();
    t_blocked();
    t_load();
    t_shadow();
    t_count();
    t_w1c();
    t_wrap_zero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule